// File: doc/BRIEF.md
# Cascaded Interrupt Priority Acknowledge Unit

This block arbitrates interrupts for a pair of chained 8-input interrupt controllers, one primary and one secondary, which together serve 16 request lines. The secondary's output is wired into primary input 2. The controllers' register contents (mask, in-service, pending request, vector base, chaining register and auto end-of-interrupt flag) are held in an external register file. That file also takes care of software programming. This block reads those registers. It returns per-bit set and clear strobes, and the register file applies them at the same clock edge. The block holds only the interrupt output and the acknowledge vector.

A request arrives as a valid/ready transfer that carries a 4-bit line number. `req_ready` drops in any cycle that carries an acknowledge. A request held during that cycle is not taken and waits. This stops an acceptance check from reading in-service state that the acknowledge is about to change. The acknowledge strobe has no back-pressure. The vector it produces is presented for exactly one cycle, marked by `vec_valid`, in the cycle after the strobe. The acceptance rules, the fixed-priority search that descends into the secondary, and the spurious-vector choice are all decided combinationally from the current register values.

Top module: `irq_cascade_arb`

## Requirements
- R1: `req_ready` is low in every cycle where `ack_strobe` is high, and high otherwise; a request is taken only when `req_valid` and `req_ready` are both high. Line numbers 0 to 7 address the primary controller and 8 to 15 address secondary local line (number − 8).
- R2: A taken primary request on line k is dropped when `m_mask[k]` or `m_isr[k]` is 1, and then no strobe is driven and `intr_o` keeps its value. Otherwise `m_irr_set` is the one-hot bit k in the same cycle, and `intr_o` is 1 from the next cycle.
- R3: A taken secondary request is dropped unless `m_cas[2]` is 1 and `s_cas` equals 8'h02.
- R4: A taken secondary request on local line k is also dropped when any `m_isr` bit is 1, or when `s_isr[k]` or `s_mask[k]` is 1.
- R5: An accepted secondary request on local line k drives `s_irr_set` bit k and raises `intr_o` from the next cycle. It also drives `m_isr_set` bit 2, unless `m_aeoi` is 1.
- R6: On an acknowledge, primary positions are searched from 0 upward. At position 2, secondary local lines 0, 2, 3, 4, 5, 6, 7 are searched first, provided the chaining is valid as in R3; primary line 2 follows. Secondary local line 1 is never selected.
- R7: In the acknowledge cycle, the selected line's pending bit is cleared through its controller's `*_irr_clr`, and its in-service bit is set through `*_isr_set` unless that controller's auto-EOI flag is 1. At most one clear bit is driven across both controllers.
- R8: `vec_valid` is high for exactly the one cycle after `ack_strobe`. In that cycle `vec_o` equals the selected controller's base plus the line index, computed modulo 256.
- R9: When the search finds nothing, no strobe is driven and `vec_o` is `s_base`+7 if `m_isr[2]` is 1, otherwise `m_base`+7.
- R10: After an acknowledge, `intr_o` is 1 only if some pending bit remains unmasked in either controller once the cleared bit is removed.
- R11: During reset, `intr_o`, `vec_valid` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request transfer valid |
| req_ready | output | 1 | Request can be taken (low during acknowledge) |
| req_line | input | 4 | Request line number 0..15 |
| ack_strobe | input | 1 | Processor interrupt acknowledge |
| m_mask | input | 8 | Primary mask register |
| m_isr | input | 8 | Primary in-service register |
| m_irr | input | 8 | Primary pending-request register |
| m_base | input | 8 | Primary vector base |
| m_cas | input | 8 | Primary chaining register |
| m_aeoi | input | 1 | Primary auto end-of-interrupt mode |
| s_mask | input | 8 | Secondary mask register |
| s_isr | input | 8 | Secondary in-service register |
| s_irr | input | 8 | Secondary pending-request register |
| s_base | input | 8 | Secondary vector base |
| s_cas | input | 8 | Secondary chaining register |
| s_aeoi | input | 1 | Secondary auto end-of-interrupt mode |
| m_irr_set | output | 8 | Primary pending bits to set |
| m_irr_clr | output | 8 | Primary pending bits to clear |
| m_isr_set | output | 8 | Primary in-service bits to set |
| s_irr_set | output | 8 | Secondary pending bits to set |
| s_irr_clr | output | 8 | Secondary pending bits to clear |
| s_isr_set | output | 8 | Secondary in-service bits to set |
| intr_o | output | 1 | Interrupt to processor |
| vec_valid | output | 1 | Vector output valid |
| vec_o | output | 8 | Acknowledge vector |

## Verification
The assertions check the following in every cycle:
- requests and acknowledges never overlap;
- each set strobe appears only when its acceptance preconditions hold;
- an acknowledge never clears more than one line;
- auto-EOI suppresses in-service setting;
- secondary line 1 is never picked;
- the vector strobe lags the acknowledge by one cycle.

Some behaviour only the bench's scenarios can show: the exact descent order at position 2, the base-plus-index arithmetic, the choice between the two spurious vectors, and whether the interrupt output falls or stays high after an acknowledge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned CTRL_LINES = 8;
  localparam int unsigned VEC_BITS   = 8;
  localparam int unsigned LINK_POS   = 2;
  localparam int unsigned SKIP_POS   = 1;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_PRIMARY,
    WIN_SECONDARY
  } win_src_e;
endpackage

// File: rtl/irq_cascade_prienc.sv
module irq_cascade_prienc #(
  parameter int unsigned N  = irq_cascade_pkg::CTRL_LINES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign onehot[g]  = vec[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | vec[g];
    end
  endgenerate

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/irq_cascade_gate.sv
module irq_cascade_gate #(
  parameter int unsigned N        = irq_cascade_pkg::CTRL_LINES,
  parameter int unsigned LINK_POS = irq_cascade_pkg::LINK_POS,
  localparam int unsigned LW      = $clog2(N)
) (
  input  logic         fire,
  input  logic [LW:0]  line,
  input  logic         link_ok,
  input  logic         m_aeoi,
  input  logic [N-1:0] m_mask,
  input  logic [N-1:0] m_isr,
  input  logic [N-1:0] s_mask,
  input  logic [N-1:0] s_isr,
  output logic         taken,
  output logic [N-1:0] m_irr_set,
  output logic [N-1:0] s_irr_set,
  output logic [N-1:0] m_isr_set
);
  localparam logic [N-1:0] LINK_BIT = N'(1) << LINK_POS;

  logic         to_secondary;
  logic [N-1:0] sel;
  logic         m_ok;
  logic         s_ok;

  always_comb begin
    to_secondary = line[LW];
    sel          = N'(1) << line[LW-1:0];
    m_ok = fire & ~to_secondary & ~|(sel & (m_mask | m_isr));
    s_ok = fire & to_secondary & link_ok & ~|m_isr
         & ~|(sel & (s_mask | s_isr));
    taken     = m_ok | s_ok;
    m_irr_set = m_ok ? sel : '0;
    s_irr_set = s_ok ? sel : '0;
    m_isr_set = (s_ok && !m_aeoi) ? LINK_BIT : '0;
  end
endmodule

// File: rtl/irq_cascade_search.sv
module irq_cascade_search #(
  parameter int unsigned N        = irq_cascade_pkg::CTRL_LINES,
  parameter int unsigned VW       = irq_cascade_pkg::VEC_BITS,
  parameter int unsigned LINK_POS = irq_cascade_pkg::LINK_POS,
  parameter int unsigned SKIP_POS = irq_cascade_pkg::SKIP_POS,
  localparam int unsigned IW      = $clog2(N)
) (
  input  logic          ack,
  input  logic          descend_ok,
  input  logic [N-1:0]  m_irr,
  input  logic [N-1:0]  s_irr,
  input  logic          m_link_busy,
  input  logic          m_aeoi,
  input  logic          s_aeoi,
  input  logic [VW-1:0] m_base,
  input  logic [VW-1:0] s_base,
  output logic [N-1:0]  m_irr_clr,
  output logic [N-1:0]  m_isr_set,
  output logic [N-1:0]  s_irr_clr,
  output logic [N-1:0]  s_isr_set,
  output logic [VW-1:0] vec_next
);
  import irq_cascade_pkg::*;

  localparam logic [N-1:0] LOW_MASK  = (N'(1) << LINK_POS) - N'(1);
  localparam logic [N-1:0] SKIP_MASK = ~(N'(1) << SKIP_POS);

  logic [N-1:0]  m_lo, m_hi, s_el;
  logic          lo_f, hi_f, sl_f;
  logic [IW-1:0] lo_i, hi_i, sl_i;
  logic [N-1:0]  lo_oh, hi_oh, sl_oh;
  win_src_e      src;
  logic [N-1:0]  win_oh;
  logic [IW-1:0] win_i;

  assign m_lo = m_irr & LOW_MASK;
  assign m_hi = m_irr & ~LOW_MASK;
  assign s_el = descend_ok ? (s_irr & SKIP_MASK) : '0;

  irq_cascade_prienc #(.N(N)) u_lo (.vec(m_lo), .found(lo_f), .idx(lo_i), .onehot(lo_oh));
  irq_cascade_prienc #(.N(N)) u_sl (.vec(s_el), .found(sl_f), .idx(sl_i), .onehot(sl_oh));
  irq_cascade_prienc #(.N(N)) u_hi (.vec(m_hi), .found(hi_f), .idx(hi_i), .onehot(hi_oh));

  always_comb begin
    src    = WIN_NONE;
    win_oh = '0;
    win_i  = '0;
    if (lo_f) begin
      src = WIN_PRIMARY;   win_oh = lo_oh; win_i = lo_i;
    end else if (sl_f) begin
      src = WIN_SECONDARY; win_oh = sl_oh; win_i = sl_i;
    end else if (hi_f) begin
      src = WIN_PRIMARY;   win_oh = hi_oh; win_i = hi_i;
    end
  end

  always_comb begin
    m_irr_clr = '0;
    m_isr_set = '0;
    s_irr_clr = '0;
    s_isr_set = '0;
    unique case (src)
      WIN_PRIMARY: begin
        vec_next = m_base + VW'(win_i);
        if (ack) begin
          m_irr_clr = win_oh;
          if (!m_aeoi) m_isr_set = win_oh;
        end
      end
      WIN_SECONDARY: begin
        vec_next = s_base + VW'(win_i);
        if (ack) begin
          s_irr_clr = win_oh;
          if (!s_aeoi) s_isr_set = win_oh;
        end
      end
      default: begin
        vec_next = m_link_busy ? (s_base + VW'(N - 1)) : (m_base + VW'(N - 1));
      end
    endcase
  end
endmodule

// File: rtl/irq_cascade_arb.sv
module irq_cascade_arb #(
  parameter int unsigned N          = irq_cascade_pkg::CTRL_LINES,
  parameter int unsigned VW         = irq_cascade_pkg::VEC_BITS,
  parameter int unsigned LINK_POS   = irq_cascade_pkg::LINK_POS,
  parameter int unsigned SKIP_POS   = irq_cascade_pkg::SKIP_POS,
  parameter bit          SEC_CHAINED = 1'b1,
  localparam int unsigned LW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [LW:0]   req_line,
  input  logic          ack_strobe,
  input  logic [N-1:0]  m_mask,
  input  logic [N-1:0]  m_isr,
  input  logic [N-1:0]  m_irr,
  input  logic [VW-1:0] m_base,
  input  logic [N-1:0]  m_cas,
  input  logic          m_aeoi,
  input  logic [N-1:0]  s_mask,
  input  logic [N-1:0]  s_isr,
  input  logic [N-1:0]  s_irr,
  input  logic [VW-1:0] s_base,
  input  logic [N-1:0]  s_cas,
  input  logic          s_aeoi,
  output logic [N-1:0]  m_irr_set,
  output logic [N-1:0]  m_irr_clr,
  output logic [N-1:0]  m_isr_set,
  output logic [N-1:0]  s_irr_set,
  output logic [N-1:0]  s_irr_clr,
  output logic [N-1:0]  s_isr_set,
  output logic          intr_o,
  output logic          vec_valid,
  output logic [VW-1:0] vec_o
);
  logic          link_ok;
  logic          fire;
  logic          taken;
  logic [N-1:0]  g_m_isr_set, k_m_isr_set;
  logic [VW-1:0] vec_next;
  logic          pend_after;
  logic          intr_q, vv_q;
  logic [VW-1:0] vec_q;

  assign req_ready = ~ack_strobe;
  assign fire      = req_valid & req_ready;
  assign link_ok   = m_cas[LINK_POS] && (s_cas == N'(LINK_POS));

  irq_cascade_gate #(.N(N), .LINK_POS(LINK_POS)) u_gate (
    .fire      (fire),
    .line      (req_line),
    .link_ok   (link_ok),
    .m_aeoi    (m_aeoi),
    .m_mask    (m_mask),
    .m_isr     (m_isr),
    .s_mask    (s_mask),
    .s_isr     (s_isr),
    .taken     (taken),
    .m_irr_set (m_irr_set),
    .s_irr_set (s_irr_set),
    .m_isr_set (g_m_isr_set)
  );

  irq_cascade_search #(.N(N), .VW(VW), .LINK_POS(LINK_POS), .SKIP_POS(SKIP_POS)) u_search (
    .ack         (ack_strobe),
    .descend_ok  (link_ok && SEC_CHAINED),
    .m_irr       (m_irr),
    .s_irr       (s_irr),
    .m_link_busy (m_isr[LINK_POS]),
    .m_aeoi      (m_aeoi),
    .s_aeoi      (s_aeoi),
    .m_base      (m_base),
    .s_base      (s_base),
    .m_irr_clr   (m_irr_clr),
    .m_isr_set   (k_m_isr_set),
    .s_irr_clr   (s_irr_clr),
    .s_isr_set   (s_isr_set),
    .vec_next    (vec_next)
  );

  assign m_isr_set  = g_m_isr_set | k_m_isr_set;
  assign pend_after = |(m_irr & ~m_irr_clr & ~m_mask) | |(s_irr & ~s_irr_clr & ~s_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      vv_q <= ack_strobe;
      if (ack_strobe) begin
        vec_q  <= vec_next;
        intr_q <= pend_after;
      end else if (taken) begin
        intr_q <= 1'b1;
      end
    end
  end

  assign intr_o    = intr_q;
  assign vec_valid = vv_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/irq_cascade_arb_chk.sv
module irq_cascade_arb_chk #(
  parameter int unsigned N        = 8,
  parameter int unsigned LINK_POS = 2,
  parameter int unsigned SKIP_POS = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack_strobe,
  input logic         req_ready,
  input logic [N-1:0] m_mask,
  input logic [N-1:0] m_isr,
  input logic [N-1:0] m_cas,
  input logic         m_aeoi,
  input logic [N-1:0] s_cas,
  input logic         s_aeoi,
  input logic [N-1:0] m_irr_set,
  input logic [N-1:0] s_irr_set,
  input logic [N-1:0] m_isr_set,
  input logic [N-1:0] m_irr_clr,
  input logic [N-1:0] s_irr_clr,
  input logic [N-1:0] s_isr_set,
  input logic         intr_o,
  input logic         vec_valid
);
  assert_ready_yields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |-> !req_ready);

  assert_primary_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_irr_set) |-> ((m_irr_set & (m_mask | m_isr)) == '0 && $countones(m_irr_set) == 1));

  assert_intr_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_o) |-> $past(|{m_irr_set, s_irr_set}));

  assert_link_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_irr_set) |-> (m_cas[LINK_POS] && s_cas == N'(LINK_POS)));

  assert_primary_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_irr_set) |-> (m_isr == '0));

  assert_aeoi_primary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_isr_set) |-> !m_aeoi);

  assert_skip_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_irr_clr[SKIP_POS]);

  assert_one_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m_irr_clr, s_irr_clr}) <= 1);

  assert_aeoi_secondary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_isr_set) |-> (!s_aeoi && s_isr_set == s_irr_clr));

  assert_vec_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |=> vec_valid);

  assert_vec_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe |=> !vec_valid);
endmodule

bind irq_cascade_arb irq_cascade_arb_chk #(
  .N(N), .LINK_POS(LINK_POS), .SKIP_POS(SKIP_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_strobe (ack_strobe),
  .req_ready  (req_ready),
  .m_mask     (m_mask),
  .m_isr      (m_isr),
  .m_cas      (m_cas),
  .m_aeoi     (m_aeoi),
  .s_cas      (s_cas),
  .s_aeoi     (s_aeoi),
  .m_irr_set  (m_irr_set),
  .s_irr_set  (s_irr_set),
  .m_isr_set  (m_isr_set),
  .m_irr_clr  (m_irr_clr),
  .s_irr_clr  (s_irr_clr),
  .s_isr_set  (s_isr_set),
  .intr_o     (intr_o),
  .vec_valid  (vec_valid)
);

// File: tb/irq_cascade_arb_bench.sv
module irq_cascade_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid = 1'b0, ack_strobe = 1'b0;
  logic [3:0] req_line = '0;
  logic [7:0] m_mask = '0, m_isr = '0, m_irr = '0, m_cas = '0;
  logic [7:0] s_mask = '0, s_isr = '0, s_irr = '0, s_cas = '0;
  logic [7:0] m_base = 8'h20, s_base = 8'h70;
  logic       m_aeoi = 1'b0, s_aeoi = 1'b0;
  logic       req_ready, intr_o, vec_valid;
  logic [7:0] m_irr_set, m_irr_clr, m_isr_set, s_irr_set, s_irr_clr, s_isr_set, vec_o;

  irq_cascade_arb u_irq_cascade_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .ack_strobe(ack_strobe),
    .m_mask(m_mask), .m_isr(m_isr), .m_irr(m_irr), .m_base(m_base), .m_cas(m_cas), .m_aeoi(m_aeoi),
    .s_mask(s_mask), .s_isr(s_isr), .s_irr(s_irr), .s_base(s_base), .s_cas(s_cas), .s_aeoi(s_aeoi),
    .m_irr_set(m_irr_set), .m_irr_clr(m_irr_clr), .m_isr_set(m_isr_set),
    .s_irr_set(s_irr_set), .s_irr_clr(s_irr_clr), .s_isr_set(s_isr_set),
    .intr_o(intr_o), .vec_valid(vec_valid), .vec_o(vec_o)
  );

  typedef struct packed {
    logic       ack;
    logic [3:0] line;
    logic [7:0] mm, mi, mr, mc;
    logic       ma;
    logic [7:0] sm, si, sr, sc;
    logic       sa;
    logic [7:0] e_mrs, e_srs, e_mis, e_mrc, e_src, e_sis, e_vec;
    logic       e_intr;
  } row_t;

  localparam int NROWS = 20;
  localparam row_t TBL [0:NROWS-1] = '{
    '{1'b0, 4'd5,  8'h20, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    '{1'b0, 4'd4,  8'h00, 8'h10, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    '{1'b0, 4'd3,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd9,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd9,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h03, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd10, 8'h00, 8'h01, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd10, 8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h04, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd10, 8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h04, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd12, 8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h10, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 4'd15, 8'h00, 8'h00, 8'h00, 8'h04, 1'b1, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h0C, 8'h04, 1'b0, 8'h00, 8'h00, 8'h01, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h70, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h08, 8'h04, 1'b0, 8'h00, 8'h00, 8'h02, 8'h02, 1'b0, 8'h00, 8'h00, 8'h08, 8'h08, 8'h00, 8'h00, 8'h23, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h02, 8'h04, 1'b0, 8'h00, 8'h00, 8'h01, 8'h02, 1'b0, 8'h00, 8'h00, 8'h02, 8'h02, 8'h00, 8'h00, 8'h21, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h80, 8'h00, 1'b0, 8'h01, 8'h00, 8'h01, 8'h02, 1'b0, 8'h00, 8'h00, 8'h80, 8'h80, 8'h00, 8'h00, 8'h27, 1'b0},
    '{1'b0, 4'd0,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h11, 8'h04, 1'b1, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h20, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h04, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h77, 1'b0},
    '{1'b0, 4'd2,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h27, 1'b0},
    '{1'b1, 4'd0,  8'h00, 8'h00, 8'h00, 8'h04, 1'b0, 8'h00, 8'h00, 8'h40, 8'h02, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 8'h76, 1'b0}
  };

  function automatic string tag(int i);
    case (i)
      0, 1, 2, 14, 17: return "R2";
      3, 4:            return "R3";
      5, 6, 7:         return "R4";
      8, 9:            return "R5 R1";
      10, 11, 12:      return "R6 R7 R8";
      13:              return "R6 R10";
      15:              return "R7 R10";
      default:         return "R9 R10";
    endcase
  endfunction

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "intr_o in reset", 32'(intr_o), 32'd0);
    chk("R11", "vec_valid in reset", 32'(vec_valid), 32'd0);
    chk("R11", "vec_o in reset", 32'(vec_o), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      req_line = TBL[i].line;
      m_mask = TBL[i].mm; m_isr = TBL[i].mi; m_irr = TBL[i].mr; m_cas = TBL[i].mc; m_aeoi = TBL[i].ma;
      s_mask = TBL[i].sm; s_isr = TBL[i].si; s_irr = TBL[i].sr; s_cas = TBL[i].sc; s_aeoi = TBL[i].sa;
      ack_strobe = TBL[i].ack;
      req_valid  = ~TBL[i].ack;
      #1;
      chk(tag(i), "m_irr_set", 32'(m_irr_set), 32'(TBL[i].e_mrs));
      chk(tag(i), "s_irr_set", 32'(s_irr_set), 32'(TBL[i].e_srs));
      chk(tag(i), "m_isr_set", 32'(m_isr_set), 32'(TBL[i].e_mis));
      chk(tag(i), "m_irr_clr", 32'(m_irr_clr), 32'(TBL[i].e_mrc));
      chk(tag(i), "s_irr_clr", 32'(s_irr_clr), 32'(TBL[i].e_src));
      chk(tag(i), "s_isr_set", 32'(s_isr_set), 32'(TBL[i].e_sis));
      @(negedge clk);
      req_valid = 1'b0;
      ack_strobe = 1'b0;
      chk(tag(i), "intr_o", 32'(intr_o), 32'(TBL[i].e_intr));
      if (TBL[i].ack) begin
        chk(tag(i), "vec_valid", 32'(vec_valid), 32'd1);
        chk(tag(i), "vec_o", 32'(vec_o), 32'(TBL[i].e_vec));
      end
    end

    // R1: request offered together with an acknowledge is not taken
    @(negedge clk);
    m_mask = '0; m_isr = '0; m_irr = '0; s_irr = '0; m_aeoi = 1'b0;
    req_line = 4'd3; req_valid = 1'b1; ack_strobe = 1'b1;
    #1;
    chk("R1", "req_ready during ack", 32'(req_ready), 32'd0);
    chk("R1", "m_irr_set during ack", 32'(m_irr_set), 32'd0);
    @(negedge clk);
    ack_strobe = 1'b0;
    chk("R1", "intr_o after blocked request", 32'(intr_o), 32'd0);
    chk("R8", "vec_valid after ack", 32'(vec_valid), 32'd1);
    #1;
    chk("R1", "req_ready without ack", 32'(req_ready), 32'd1);
    chk("R1", "m_irr_set once ready", 32'(m_irr_set), 32'h08);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "vec_valid single cycle", 32'(vec_valid), 32'd0);
    chk("R2", "intr_o after retry", 32'(intr_o), 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule